// File: doc/BRIEF.md
# Token-Chained Almost-Full Flag Bus Scanner

This block puts the almost-full status of a 32-queue device onto a narrow flag bus, one group of eight queues (a quadrant) at a time. The status flags are active low: a 0 on a bus bit means that queue is almost full. Two modes are available, chosen by a static mode input that is changed only while reset is held. In direct mode a write-side controller picks the quadrant to show by pulsing a strobe together with an address. In polled mode the quadrants are stepped through on successive write clock edges with no controller involvement.

Several devices can share one flag bus. In polled mode a one-cycle token travels around a ring made of each device's token output wired to the next device's token input. Only the device that holds the token drives the bus. All other devices drive all-ones, which reads as "no queue almost full". A sync output marks the cycle in which a device shows its first quadrant, so a reader can tell where each device's group of four begins. With a single device, the token output is looped back to its own token input and the four quadrants repeat without a break.

Top module: `flagscan_top`

## Requirements
- R1: Reset is synchronous to the write clock. In the cycle after a clocked reset, the sync and token outputs are low and the flag bus is all ones.
- R2: In polled mode, while the device holds the token, successive write clock edges show quadrant 1, 2, 3 and 4. When the token output is looped back to the token input, the following edge shows quadrant 1 again.
- R3: In polled mode, the sync output is high for exactly the cycle in which quadrant 1 is shown, and low for the cycles of quadrants 2 to 4.
- R4: In polled mode, the token output is high for exactly the cycle in which quadrant 4 is shown, and low at every other time.
- R5: In polled mode, a high token input at a clock edge makes the device show quadrant 1 from that edge on. A device without the token shows all ones. After quadrant 4, if no token arrives, the device releases the bus (all ones) on the next edge.
- R6: In polled mode, the device configured as master holds the token first after reset: the first edge after reset shows quadrant 1 with sync high, with no token input needed. A non-master device shows all ones until a token arrives.
- R7: In direct mode, a strobe at a clock edge whose address bits [7:5] match the latched device ID selects quadrant number wrAddr[4:3] + 1 (0 means quadrant 1). Quadrant k (0-based) shows queues 8k to 8k+7, with bus bit i carrying the flag of queue 8k+i.
- R8: In direct mode, a strobe whose ID field does not match releases the bus (all ones). Without a strobe, the current selection is kept whatever the address does.
- R9: In direct mode, the token input has no effect, and the sync and token outputs stay low.
- R10: In polled mode, the strobe input and the address have no effect on the quadrant sequence.
- R11: The device ID is latched while reset is held. Changes on the ID pins after reset do not change which address matches.
- R12: The flag bus follows the live flag inputs of the shown quadrant in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst | input | 1 | Synchronous reset, active high |
| pollMode | input | 1 | 1 = polled token-ring mode, 0 = direct strobe mode; static |
| isMaster | input | 1 | Device takes the token first after reset (polled mode) |
| deviceId | input | 3 | Device ID, latched during reset |
| almostFullN | input | 32 | Active-low almost-full flags, bit q for queue q |
| flagStrobe | input | 1 | Direct-mode quadrant select strobe |
| wrAddr | input | 8 | Write address: [7:5] device ID, [4:3] quadrant, [2:0] queue in quadrant |
| tokenIn | input | 1 | Token from the previous device in the ring |
| flagBusN | output | 8 | Active-low flag bus for the shown quadrant, all ones when idle |
| syncOut | output | 1 | High while this device shows its quadrant 1 |
| tokenOut | output | 1 | High while this device shows its quadrant 4 |

## Verification
The hardest case to reach is the hand-off at the end of a non-master device's group of four. The token must be absent at the right edge so that the device drops the bus, rather than reloading quadrant 1 as it does in the looped single-device case. The stimulus reaches this by resetting the device as a slave, holding the token input low long enough to show that it stays idle, and then pulsing the token for one edge. It then follows quadrants 1 to 4 and checks the release on the fifth edge. The direct-mode sequences change the ID pins after reset and change flag values mid-selection, so that the latched ID and the combinational bus path are each tested on their own.

// File: rtl/flagscan_pkg.sv
package flagscan_pkg;

  // Command strobes sent from the control unit to the datapath.
  typedef struct packed {
    logic loadFirst;  // take the token: show quadrant 1
    logic advance;    // polled stepping enabled this edge
    logic select;     // direct: capture quadrant and own the bus
    logic deselect;   // direct: another device was addressed
  } scanCmd_t;

endpackage

// File: rtl/flagscan_ctrl.sv
module flagscan_ctrl
  import flagscan_pkg::*;
#(
  parameter int NUM_QUEUES = 32,
  parameter int NUM_QUADS  = 4,
  parameter int ID_W       = 3
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  pollMode,
  input  logic                                  isMaster,
  input  logic [ID_W-1:0]                       deviceId,
  input  logic                                  flagStrobe,
  input  logic [ID_W+$clog2(NUM_QUEUES)-1:0]    wrAddr,
  input  logic                                  tokenIn,
  output scanCmd_t                              cmd,
  output logic [$clog2(NUM_QUADS)-1:0]          capQuad
);

  localparam int QFIELD_W = $clog2(NUM_QUEUES);
  localparam int QSEL_W   = $clog2(NUM_QUADS);
  localparam int ADDR_W   = ID_W + QFIELD_W;
  localparam int LOW_W    = QFIELD_W - QSEL_W;

  logic [ID_W-1:0] idLatched;
  logic            armed;
  logic            idMatch;
  logic            unusedQueueBits;

  // The ID pins are sampled only while reset is held.
  always_ff @(posedge clk) begin
    if (rst) idLatched <= deviceId;
  end

  // A master starts with a pending token that the first edge after reset consumes.
  always_ff @(posedge clk) begin
    if (rst) armed <= isMaster;
    else     armed <= 1'b0;
  end

  assign idMatch = (wrAddr[ADDR_W-1 -: ID_W] == idLatched);
  assign capQuad = wrAddr[QFIELD_W-1 -: QSEL_W];
  assign unusedQueueBits = &{1'b0, wrAddr[LOW_W-1:0]};

  always_comb begin
    cmd = '0;
    if (pollMode) begin
      cmd.loadFirst = armed | tokenIn;
      cmd.advance   = ~(armed | tokenIn);
    end else begin
      cmd.select    = flagStrobe & idMatch;
      cmd.deselect  = flagStrobe & ~idMatch;
    end
  end

endmodule

// File: rtl/flagscan_mux.sv
module flagscan_mux #(
  parameter int NUM_QUEUES = 32,
  parameter int NUM_QUADS  = 4
) (
  input  logic [NUM_QUEUES-1:0]           almostFullN,
  input  logic [$clog2(NUM_QUADS)-1:0]    quadSel,
  input  logic                            driveBus,
  output logic [NUM_QUEUES/NUM_QUADS-1:0] flagBusN
);

  localparam int QUAD_W = NUM_QUEUES / NUM_QUADS;

  logic [QUAD_W-1:0] quadSlice [NUM_QUADS];

  for (genvar g = 0; g < NUM_QUADS; g++) begin : gSlice
    assign quadSlice[g] = almostFullN[g*QUAD_W +: QUAD_W];
  end

  // An idle device drives all ones so it never masks another device's flags.
  assign flagBusN = driveBus ? quadSlice[quadSel] : '1;

endmodule

// File: rtl/flagscan_dp.sv
module flagscan_dp
  import flagscan_pkg::*;
#(
  parameter int NUM_QUEUES = 32,
  parameter int NUM_QUADS  = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  scanCmd_t                        cmd,
  input  logic [$clog2(NUM_QUADS)-1:0]    capQuad,
  input  logic [NUM_QUEUES-1:0]           almostFullN,
  output logic [NUM_QUEUES/NUM_QUADS-1:0] flagBusN,
  output logic                            syncOut,
  output logic                            tokenOut
);

  localparam int QSEL_W = $clog2(NUM_QUADS);
  localparam logic [QSEL_W-1:0] LAST_Q = QSEL_W'(NUM_QUADS - 1);
  localparam logic [QSEL_W-1:0] PREV_Q = QSEL_W'(NUM_QUADS - 2);

  logic              active;
  logic [QSEL_W-1:0] quad;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      quad     <= '0;
      syncOut  <= 1'b0;
      tokenOut <= 1'b0;
    end else begin
      syncOut  <= cmd.loadFirst;
      tokenOut <= cmd.advance & active & (quad == PREV_Q);
      if (cmd.loadFirst) begin
        active <= 1'b1;
        quad   <= '0;
      end else if (cmd.advance && active) begin
        if (quad == LAST_Q) active <= 1'b0;
        else                quad   <= quad + 1'b1;
      end else if (cmd.select) begin
        active <= 1'b1;
        quad   <= capQuad;
      end else if (cmd.deselect) begin
        active <= 1'b0;
      end
    end
  end

  flagscan_mux #(
    .NUM_QUEUES(NUM_QUEUES),
    .NUM_QUADS (NUM_QUADS)
  ) uMux (
    .almostFullN(almostFullN),
    .quadSel    (quad),
    .driveBus   (active),
    .flagBusN   (flagBusN)
  );

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (!active && !syncOut && !tokenOut));

  assert_poll_step_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd.advance && active && quad != LAST_Q) |=> (quad == $past(quad) + 1'b1));

  assert_sync_quad1_R3: assert property (@(posedge clk) disable iff (rst)
    syncOut |-> (active && quad == '0));

  assert_token_last_R4: assert property (@(posedge clk) disable iff (rst)
    tokenOut |-> (active && quad == LAST_Q));

  assert_cmd_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd.loadFirst, cmd.advance, cmd.select, cmd.deselect}));

endmodule

// File: rtl/flagscan_top.sv
module flagscan_top
  import flagscan_pkg::*;
#(
  parameter int NUM_QUEUES = 32,
  parameter int NUM_QUADS  = 4,
  parameter int ID_W       = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            pollMode,
  input  logic                            isMaster,
  input  logic [ID_W-1:0]                 deviceId,
  input  logic [NUM_QUEUES-1:0]           almostFullN,
  input  logic                            flagStrobe,
  input  logic [ID_W+$clog2(NUM_QUEUES)-1:0] wrAddr,
  input  logic                            tokenIn,
  output logic [NUM_QUEUES/NUM_QUADS-1:0] flagBusN,
  output logic                            syncOut,
  output logic                            tokenOut
);

  localparam int QSEL_W = $clog2(NUM_QUADS);

  scanCmd_t          cmd;
  logic [QSEL_W-1:0] capQuad;

  flagscan_ctrl #(
    .NUM_QUEUES(NUM_QUEUES),
    .NUM_QUADS (NUM_QUADS),
    .ID_W      (ID_W)
  ) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .pollMode  (pollMode),
    .isMaster  (isMaster),
    .deviceId  (deviceId),
    .flagStrobe(flagStrobe),
    .wrAddr    (wrAddr),
    .tokenIn   (tokenIn),
    .cmd       (cmd),
    .capQuad   (capQuad)
  );

  flagscan_dp #(
    .NUM_QUEUES(NUM_QUEUES),
    .NUM_QUADS (NUM_QUADS)
  ) uDp (
    .clk        (clk),
    .rst        (rst),
    .cmd        (cmd),
    .capQuad    (capQuad),
    .almostFullN(almostFullN),
    .flagBusN   (flagBusN),
    .syncOut    (syncOut),
    .tokenOut   (tokenOut)
  );

  assert_direct_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !pollMode |-> (!syncOut && !tokenOut));

endmodule

// File: tb/tb_flagscan_top.sv
module tb_flagscan_top;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] bus;
    logic       sync;
    logic       tok;
    string      tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pollMode = 1'b1;
  logic        isMaster = 1'b1;
  logic [2:0]  deviceId = 3'b000;
  logic [31:0] almostFullN = {8'hE7, 8'hDB, 8'hBD, 8'h7E};
  logic        flagStrobe = 1'b0;
  logic [7:0]  wrAddr = 8'h00;
  logic        tokenIn = 1'b0;
  logic [7:0]  flagBusN;
  logic        syncOut;
  logic        tokenOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  expItem_t expQ[$];

  localparam logic [7:0] Q1 = 8'h7E, Q2 = 8'hBD, Q3 = 8'hDB, Q4 = 8'hE7, IDLE = 8'hFF;

  always #(CLK_PERIOD/2) clk = ~clk;

  flagscan_top dut (
    .clk(clk), .rst(rst), .pollMode(pollMode), .isMaster(isMaster),
    .deviceId(deviceId), .almostFullN(almostFullN), .flagStrobe(flagStrobe),
    .wrAddr(wrAddr), .tokenIn(tokenIn), .flagBusN(flagBusN),
    .syncOut(syncOut), .tokenOut(tokenOut)
  );

  // Driver: apply inputs for one edge and queue the outputs expected after it.
  task automatic step(input logic stb, input logic [7:0] addr, input logic tok,
                      input logic r, input logic [7:0] eBus, input logic eSync,
                      input logic eTok, input string tag);
    expItem_t e;
    @(negedge clk);
    flagStrobe = stb; wrAddr = addr; tokenIn = tok; rst = r;
    @(posedge clk);
    #1;
    e.bus = eBus; e.sync = eSync; e.tok = eTok; e.tag = tag;
    expQ.push_back(e);
  endtask

  function automatic logic [7:0] dAddr(input logic [2:0] id, input logic [1:0] q);
    return {id, q, 3'b000};
  endfunction

  // Monitor: compare outputs well after the edge and before the next input change.
  always @(posedge clk) begin
    #3;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if (flagBusN !== e.bus || syncOut !== e.sync || tokenOut !== e.tok) begin
        errors++;
        $display("FAIL %s: actual bus=%h sync=%b tok=%b expected bus=%h sync=%b tok=%b",
                 e.tag, flagBusN, syncOut, tokenOut, e.bus, e.sync, e.tok);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // Polled single device, master, token looped back by the bench.
    step(0, 0, 0, 1, IDLE, 0, 0, "R1 reset");
    step(0, 0, 0, 1, IDLE, 0, 0, "R1 reset hold");
    step(0, 0, 0, 0, Q1, 1, 0, "R6 master first q1");
    step(1, dAddr(3'b000, 2'd2), 0, 0, Q2, 0, 0, "R10 strobe ignored q2");
    step(0, 0, 0, 0, Q3, 0, 0, "R2 q3");
    step(0, 0, 0, 0, Q4, 0, 1, "R4 q4 token");
    step(0, 0, 1, 0, Q1, 1, 0, "R2 wrap q1 R3 sync");
    step(0, 0, 0, 0, Q2, 0, 0, "R3 sync low q2");
    step(0, 0, 0, 0, Q3, 0, 0, "R2 q3 again");
    step(0, 0, 0, 0, Q4, 0, 1, "R4 q4 again");
    step(0, 0, 1, 0, Q1, 1, 0, "R2 second wrap");

    // Polled slave in a ring: idle until the token, then release.
    isMaster = 1'b0;
    step(0, 0, 0, 1, IDLE, 0, 0, "R1 reset slave");
    step(0, 0, 0, 0, IDLE, 0, 0, "R6 slave idle");
    step(0, 0, 0, 0, IDLE, 0, 0, "R5 no token idle");
    step(0, 0, 1, 0, Q1, 1, 0, "R5 token loads q1");
    step(0, 0, 0, 0, Q2, 0, 0, "R5 q2");
    step(0, 0, 0, 0, Q3, 0, 0, "R5 q3");
    step(0, 0, 0, 0, Q4, 0, 1, "R5 q4 token out");
    step(0, 0, 0, 0, IDLE, 0, 0, "R5 release");
    step(0, 0, 0, 0, IDLE, 0, 0, "R4 token low idle");

    // Direct mode with ID 101 latched, then the ID pins changed.
    pollMode = 1'b0; deviceId = 3'b101;
    step(0, 0, 0, 1, IDLE, 0, 0, "R1 reset direct");
    deviceId = 3'b010;
    step(0, 0, 0, 0, IDLE, 0, 0, "R1 direct idle");
    step(1, dAddr(3'b101, 2'd2), 0, 0, Q3, 0, 0, "R7 R11 select q3");
    step(0, dAddr(3'b101, 2'd0), 0, 0, Q3, 0, 0, "R8 hold no strobe");
    step(1, dAddr(3'b101, 2'd1), 1, 0, Q2, 0, 0, "R7 select q2 R9 token ignored");
    step(1, dAddr(3'b101, 2'd3), 0, 0, Q4, 0, 0, "R7 select q4");
    step(1, dAddr(3'b010, 2'd0), 0, 0, IDLE, 0, 0, "R8 R11 other id release");
    step(0, 0, 1, 0, IDLE, 0, 0, "R9 token no effect");
    step(1, dAddr(3'b101, 2'd0), 0, 0, Q1, 0, 0, "R7 select q1");
    @(negedge clk);
    almostFullN[7:0] = 8'h5A;
    step(0, 0, 0, 0, 8'h5A, 0, 0, "R12 live flags");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule